// File: doc/BRIEF.md
# Serial Reciprocal Quantizer

This block quantizes transform coefficients of an 8x8 block without a divider. Each 12-bit two's complement coefficient enters one bit per clock, least significant bit first. A six-bit position index comes with it. The index selects a reciprocal of that position's normalization step from an internal table. The reciprocal is held as the parallel operand of a serial-parallel multiply-accumulate. After the last bit, the product is rounded symmetrically about zero, scaled back by the fraction width, and clamped to 12 bits. It is then presented with a one-cycle valid strobe.

A two-bit scale selector coarsens the quantization by powers of two. Setting it to s multiplies every step by 2^s, which is done by shifting the stored reciprocal right by s places. Frames may follow each other with no gap. Asserting start in the middle of a frame abandons that frame and begins a new one.

Top module: `serial_quantizer`

## Requirements
- R1: While rst_ni is low and after its release until the first result, valid_o is 0 and q_o is 0.
- R2: A frame is 12 consecutive cycles. In the first cycle start_i is 1. bit_i carries coefficient bit k in frame cycle k (bit 0 first, bit 11 the two's complement sign). idx_i and scale_i are taken only in the first cycle; their values in later cycles have no effect.
- R3: valid_o is 1 for exactly one cycle, the cycle after the frame's twelfth bit is sampled, and is 0 in every other cycle. q_o keeps the last result until the next one.
- R4: The reciprocal for a position is r = floor((512 + floor(N/2)) / N), where N is the step. The index is row-major: idx = 8*row + column.
- R5: The step table in row order is: 16 11 10 16 24 40 51 61 / 12 12 14 19 26 58 60 55 / 14 13 16 24 40 57 69 56 / 14 17 22 29 51 87 80 62 / 18 22 37 56 68 109 103 77 / 24 35 55 64 81 104 113 92 / 49 64 78 87 103 121 120 101 / 72 92 95 98 112 100 103 99.
- R6: q_o = sign(C) * floor((|C|*r' + 256) / 512), with r' the effective reciprocal. Rounding is therefore symmetric about zero, and C = 0 gives 0.
- R7: scale_i = s (0 to 3) gives r' = floor(r / 2^s).
- R8: A new start_i may come in the cycle right after a frame's last bit. Both frames then produce correct results 12 cycles apart.
- R9: start_i during an unfinished frame discards it. No result appears for the discarded frame, and the new frame completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks the first bit of a frame |
| bit_i | input | 1 | Serial coefficient bit, LSB first |
| idx_i | input | 6 | Row-major coefficient position, taken at start |
| scale_i | input | 2 | Step scale exponent, taken at start |
| q_o | output | 12 | Quantized coefficient, two's complement |
| valid_o | output | 1 | One-cycle strobe for a new q_o |

## Verification
The outputs show a wrong internal state at the frame's result strobe, twelve cycles after start. A bad table word or scale shift gives a wrong quotient for that position only. A slip in the bit counter moves or drops the strobe. A sign error in the last-bit subtraction hits every negative coefficient. The sweep covers every position and every scale, using extreme, small and exact half-way coefficients. Because of this, each such fault appears within one frame of the affected position.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int DATA_W  = 12;
  localparam int RECIP_W = 9;
  localparam int IDX_W   = 6;
  localparam int SCALE_W = 2;
  localparam int DEPTH   = 1 << IDX_W;

  localparam logic [7:0] STEPS [DEPTH] = '{
    8'd16, 8'd11, 8'd10, 8'd16, 8'd24, 8'd40, 8'd51, 8'd61,
    8'd12, 8'd12, 8'd14, 8'd19, 8'd26, 8'd58, 8'd60, 8'd55,
    8'd14, 8'd13, 8'd16, 8'd24, 8'd40, 8'd57, 8'd69, 8'd56,
    8'd14, 8'd17, 8'd22, 8'd29, 8'd51, 8'd87, 8'd80, 8'd62,
    8'd18, 8'd22, 8'd37, 8'd56, 8'd68, 8'd109, 8'd103, 8'd77,
    8'd24, 8'd35, 8'd55, 8'd64, 8'd81, 8'd104, 8'd113, 8'd92,
    8'd49, 8'd64, 8'd78, 8'd87, 8'd103, 8'd121, 8'd120, 8'd101,
    8'd72, 8'd92, 8'd95, 8'd98, 8'd112, 8'd100, 8'd103, 8'd99
  };

  // rounded 2^RECIP_W / step
  function automatic int unsigned recip_of(input int unsigned i);
    int unsigned n;
    n = int'(STEPS[i]);
    return ((1 << RECIP_W) + n / 2) / n;
  endfunction
endpackage

// File: rtl/sq_recip_rom.sv
module sq_recip_rom #(
  parameter int IDX_W   = sq_pkg::IDX_W,
  parameter int RECIP_W = sq_pkg::RECIP_W,
  parameter int SCALE_W = sq_pkg::SCALE_W
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [RECIP_W-1:0] recip_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [RECIP_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign words[g] = RECIP_W'(sq_pkg::recip_of(g));
  end

  assign recip_o = words[idx_i] >> scale_i;
endmodule

// File: rtl/sq_serial_mac.sv
module sq_serial_mac #(
  parameter int DATA_W  = sq_pkg::DATA_W,
  parameter int RECIP_W = sq_pkg::RECIP_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      bit_i,
  input  logic [RECIP_W-1:0]        recip_i,
  output logic                      done_o,
  output logic [DATA_W+RECIP_W:0]   prod_o
);
  localparam int PW = DATA_W + RECIP_W + 1;
  localparam int CW = $clog2(DATA_W);

  logic          busy_q;
  logic [CW-1:0] cnt_q, cnt_cur;
  logic [PW-1:0] acc_q, acc_base, acc_d;
  logic [PW-1:0] opnd_q, opnd_cur;
  logic          active, last;

  always_comb begin
    active   = start_i | busy_q;
    cnt_cur  = start_i ? '0 : cnt_q;
    opnd_cur = start_i ? PW'(recip_i) : opnd_q;
    acc_base = start_i ? '0 : acc_q;
    last     = active && (cnt_cur == CW'(DATA_W - 1));
    acc_d    = acc_base;
    if (bit_i) acc_d = last ? acc_base - opnd_cur : acc_base + opnd_cur;  // sign bit weighs negative
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      opnd_q <= '0;
    end else if (active) begin
      busy_q <= !last;
      cnt_q  <= CW'(cnt_cur + 1'b1);
      acc_q  <= acc_d;
      opnd_q <= opnd_cur << 1;
    end
  end

  assign done_o = last;
  assign prod_o = acc_d;

  assert_busy_after_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= CW'(DATA_W - 1));
endmodule

// File: rtl/sq_round_sat.sv
module sq_round_sat #(
  parameter int DATA_W  = sq_pkg::DATA_W,
  parameter int RECIP_W = sq_pkg::RECIP_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [DATA_W+RECIP_W:0] prod_i,
  output logic [DATA_W-1:0]       q_o,
  output logic                    valid_o
);
  localparam int PW = DATA_W + RECIP_W + 1;
  localparam logic [PW-1:0] HALF    = PW'(1) << (RECIP_W - 1);
  localparam logic [PW-1:0] POS_LIM = (PW'(1) << (DATA_W - 1)) - PW'(1);
  localparam logic [PW-1:0] NEG_LIM = PW'(1) << (DATA_W - 1);

  logic              neg;
  logic [PW-1:0]     mag, quo, lim, sat;
  logic [DATA_W-1:0] q_d;

  always_comb begin
    neg = prod_i[PW-1];
    mag = neg ? PW'(0) - prod_i : prod_i;
    quo = (mag + HALF) >> RECIP_W;
    lim = neg ? NEG_LIM : POS_LIM;
    sat = (quo > lim) ? lim : quo;
    q_d = neg ? DATA_W'(PW'(0) - sat) : DATA_W'(sat);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) q_o <= q_d;
    end
  end

  assert_sign_follows_product_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && q_o != '0) |-> (q_o[DATA_W-1] == $past(prod_i[PW-1])));
  assert_zero_product_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(prod_i) == '0) |-> q_o == '0);
  assert_hold_between_results_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(q_o) || $past(load_i));
endmodule

// File: rtl/serial_quantizer.sv
module serial_quantizer #(
  parameter int DATA_W  = sq_pkg::DATA_W,
  parameter int RECIP_W = sq_pkg::RECIP_W,
  parameter int SCALE_W = sq_pkg::SCALE_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         bit_i,
  input  logic [sq_pkg::IDX_W-1:0]     idx_i,
  input  logic [SCALE_W-1:0]           scale_i,
  output logic [DATA_W-1:0]            q_o,
  output logic                         valid_o
);
  localparam int IDX_W = sq_pkg::IDX_W;
  localparam int PW    = DATA_W + RECIP_W + 1;

  logic [RECIP_W-1:0] recip;
  logic               mac_done;
  logic [PW-1:0]      prod;

  sq_recip_rom #(.IDX_W(IDX_W), .RECIP_W(RECIP_W), .SCALE_W(SCALE_W)) u_rom (
    .idx_i   (idx_i),
    .scale_i (scale_i),
    .recip_o (recip)
  );

  sq_serial_mac #(.DATA_W(DATA_W), .RECIP_W(RECIP_W)) u_mac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .bit_i   (bit_i),
    .recip_i (recip),
    .done_o  (mac_done),
    .prod_o  (prod)
  );

  sq_round_sat #(.DATA_W(DATA_W), .RECIP_W(RECIP_W)) u_rnd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (mac_done),
    .prod_i  (prod),
    .q_o     (q_o),
    .valid_o (valid_o)
  );

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_done |=> valid_o);
  assert_single_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: tb/sim_serial_quantizer.sv
`timescale 1ns/1ps
module sim_serial_quantizer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sbit = 1'b0;
  logic [5:0] idx = '0;
  logic [1:0] scale = '0;
  logic [11:0] q;
  logic valid;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int steps [64] = '{16,11,10,16,24,40,51,61, 12,12,14,19,26,58,60,55,
                     14,13,16,24,40,57,69,56, 14,17,22,29,51,87,80,62,
                     18,22,37,56,68,109,103,77, 24,35,55,64,81,104,113,92,
                     49,64,78,87,103,121,120,101, 72,92,95,98,112,100,103,99};
  int vals [10] = '{0, 1, -1, 2047, -2048, 255, -256, 100, -100, 777};

  always #10 clk = ~clk;

  serial_quantizer u0 (.clk_i(clk), .rst_ni(rst_n), .start_i(start), .bit_i(sbit),
                       .idx_i(idx), .scale_i(scale), .q_o(q), .valid_o(valid));

  function automatic int expq(int c, int i, int s);
    int r, m, mag;
    r = ((512 + steps[i] / 2) / steps[i]) >>> s;
    mag = (c < 0) ? -c : c;
    m = (mag * r + 256) / 512;
    if (c >= 0 && m > 2047) m = 2047;
    if (c < 0 && m > 2048) m = 2048;
    return (c < 0) ? -m : m;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 12 frame cycles; optionally checks the previous frame's result at this frame's first cycle
  task automatic drive_bits(int c, int i, int s, bit chk_prev, int exp_prev);
    logic [11:0] cv;
    cv = 12'(c);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 0 && chk_prev) begin
        check("R8 back-to-back valid", int'(valid), 1);
        check("R8 back-to-back value", int'($signed(q)), exp_prev);
      end
      if (k == 6) check("R3 no strobe mid-frame", int'(valid), 0);
      start = (k == 0);
      sbit  = cv[k];
      if (k == 0) begin idx = 6'(i); scale = 2'(s); end
      else begin idx = ~6'(i); scale = ~2'(s); end  // R2: later values ignored
    end
  endtask

  task automatic finish_frame(string req, int exp);
    @(negedge clk);
    start = 1'b0; sbit = 1'b0;
    check({req, " valid"}, int'(valid), 1);
    check(req, int'($signed(q)), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(valid), 0);
    check("R1 reset q", int'(q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release valid", int'(valid), 0);
    check("R1 after release q", int'(q), 0);

    // sweep all positions and scales
    for (int i = 0; i < 64; i++)
      for (int s = 0; s < 4; s++)
        for (int v = 0; v < 10; v++) begin
          drive_bits(vals[v], i, s, 0, 0);
          finish_frame("R2 R4 R5 R6 R7 sweep", expq(vals[v], i, s));
        end

    // half-way rounding at step 16 (r=32): 8*32 = 256
    drive_bits(8, 0, 0, 0, 0);  finish_frame("R6 half up", 1);
    drive_bits(-8, 0, 0, 0, 0); finish_frame("R6 half symmetric", -1);
    drive_bits(7, 0, 0, 0, 0);  finish_frame("R6 below half", 0);
    drive_bits(-7, 0, 0, 0, 0); finish_frame("R6 below half neg", 0);
    drive_bits(-431, 0, 0, 0, 0); finish_frame("R6 dc example", -27);
    drive_bits(100, 2, 3, 0, 0); finish_frame("R7 coarse scale", expq(100, 2, 3));

    // hold after strobe
    repeat (5) @(negedge clk);
    check("R3 strobe one cycle", int'(valid), 0);
    check("R3 value held", int'($signed(q)), expq(100, 2, 3));

    // back-to-back frames
    drive_bits(1500, 9, 0, 0, 0);
    drive_bits(-1999, 63, 1, 1, expq(1500, 9, 0));
    finish_frame("R8 second frame", expq(-1999, 63, 1));

    // restart mid-frame
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      start = (k == 0); sbit = 1'b1; idx = 6'd2; scale = 2'd0;
    end
    @(negedge clk);
    check("R9 no strobe before restart", int'(valid), 0);
    drive_bits(-600, 41, 0, 0, 0);
    finish_frame("R9 restarted frame", expq(-600, 41, 0));
    @(negedge clk);
    check("R9 no extra strobe", int'(valid), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule